// File: doc/BRIEF.md
# I2C Target Status Flags

This block turns bus events from an I2C target bit engine, together with the fill levels of the target's small transmit and receive FIFOs, into five status flags and one interrupt request. The bit engine reports SCL edges, the R/W bit slot, the value of that bit, a match of the target address, and START and STOP conditions. Each of these reports is a one-cycle pulse, or a level, in the system clock domain. The FIFOs report full and empty levels and a strobe for every byte pushed into the receive FIFO. Software reads the packed status word, and that read is signalled by a one-cycle strobe.

Every flag is registered. A flag changes in the cycle after the event that causes it. A control bit selects early-transmit mode, and that mode does two things. It moves the transmit request from the falling SCL edge of the R/W bit to the rising edge of that bit. It also turns the lowest status bit into a one-shot event that fires once per transfer and is cleared by a status read.

Top module: `i2c_tgt_status`

## Requirements
- R1: The overflow flag (`status[4]`) sets in the cycle after `rx_wr` is asserted while `rx_full` is high. It clears after a later `rx_wr` while `rx_full` is low, or when `rx_empty` is high. Otherwise it keeps its value.
- R2: The receive request flag (`status[3]`) equals the inverse of `rx_empty` as it was one cycle earlier.
- R3: The transmit request flag (`status[2]`) sets one cycle after an SCL edge that occurs while `rw_slot`, `rw_read` and `addr_hit` are all high. With `early_en` low, that edge is `scl_fall`. With `early_en` high, it is `scl_rise`. The other edge does not set the flag.
- R4: A `start_det` or `stop_det` pulse clears the transmit request flag and the underflow flag in the following cycle.
- R5: The underflow flag (`status[1]`) sets one cycle after `scl_rise` during a matched read bit while `tx_empty` is high. It does not set while `tx_empty` is low.
- R6: With `early_en` low, the early-transmit flag (`status[0]`) equals `tx_empty` delayed by one cycle.
- R7: With `early_en` high, the early-transmit flag sets one cycle after `scl_rise` while `rw_slot` and `addr_hit` are high, whatever the R/W value. It sets at most once between two START or STOP pulses.
- R8: With `early_en` high, a `stat_rd` pulse clears the early-transmit flag in the following cycle. If a setting edge arrives in the same cycle as `stat_rd`, the set takes priority.
- R9: `irq` is the level-sensitive OR of (`status[3]` AND `rx_irq_en`) and (`status[2]` AND `tx_irq_en`). It responds combinationally to the enables.
- R10: While `rst` is high, and in the first cycle after it falls, all five status bits and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_rise | input | 1 | Pulse on a rising SCL edge |
| scl_fall | input | 1 | Pulse on a falling SCL edge |
| rw_slot | input | 1 | High while the bit engine is in the R/W bit slot |
| rw_read | input | 1 | Value of the R/W bit, 1 = master reads |
| addr_hit | input | 1 | Address bits matched this target |
| start_det | input | 1 | Pulse on a START or repeated START |
| stop_det | input | 1 | Pulse on a STOP |
| rx_wr | input | 1 | Pulse when a byte is pushed into the receive FIFO |
| rx_full | input | 1 | Receive FIFO is full |
| rx_empty | input | 1 | Receive FIFO is empty |
| tx_empty | input | 1 | Transmit FIFO is empty |
| stat_rd | input | 1 | Pulse when software reads the status word |
| early_en | input | 1 | Early-transmit mode select |
| rx_irq_en | input | 1 | Receive request interrupt enable |
| tx_irq_en | input | 1 | Transmit request interrupt enable |
| status | output | 5 | {overflow, rx request, tx request, underflow, early transmit} |
| irq | output | 1 | Interrupt request, level |

## Verification
On every cycle, the embedded properties check the following:
- Every rising edge of the transmit request and underflow flags is preceded by the correct SCL edge and FIFO condition.
- START and STOP clear the transfer flags.
- A status read clears the early-transmit flag.
- The early-transmit flag never rises twice in one transfer.
- The interrupt stays low with both enables off.

Only the directed scenarios can show the following:
- The edge chosen by each mode leaves the flag low on the other edge.
- The overflow flag holds and releases as the FIFO levels change.
- The one-shot re-arms on the next transfer.
- The packed bit order is correct.

// File: rtl/i2c_tgt_status_pkg.sv
package i2c_tgt_status_pkg;

   localparam int STAT_W   = 5;
   localparam int IDX_OVF  = 4;
   localparam int IDX_RXRQ = 3;
   localparam int IDX_TXRQ = 2;
   localparam int IDX_UNF  = 1;
   localparam int IDX_ETX  = 0;

   // packed msb first: ovf lands on bit 4, etx on bit 0
   typedef struct packed {
      logic ovf;
      logic rxrq;
      logic txrq;
      logic unf;
      logic etx;
   } stat_t;

   typedef struct packed {
      logic scl_rise;
      logic scl_fall;
      logic rw_slot;
      logic rw_read;
      logic addr_hit;
      logic start;
      logic stop;
   } bus_ev_t;

endpackage

// File: rtl/i2c_tgt_rx_flags.sv
module i2c_tgt_rx_flags #(
   parameter int RXREQ_REGISTERED = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic rx_wr,
   input  logic rx_full,
   input  logic rx_empty,
   output logic ovf,
   output logic rxrq
);

   initial begin : p_param_chk
      assert (RXREQ_REGISTERED == 0 || RXREQ_REGISTERED == 1)
         else $error("RXREQ_REGISTERED must be 0 or 1");
   end

   logic ovf_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ovf_q <= 1'b0;
      end else if (rx_wr) begin
         ovf_q <= rx_full;
      end else if (rx_empty) begin
         ovf_q <= 1'b0;
      end
   end

   assign ovf = ovf_q;

   generate
      if (RXREQ_REGISTERED == 1) begin : g_rxrq_reg
         logic rxrq_q;
         always_ff @(posedge clk) begin
            if (rst) rxrq_q <= 1'b0;
            else     rxrq_q <= ~rx_empty;
         end
         assign rxrq = rxrq_q;

         // R2: request only rises after the FIFO held data
         a_r2_rxrq_rise : assert property (@(posedge clk) disable iff (rst)
            $rose(rxrq) |-> $past(!rx_empty));
         a_r2_rxrq_fall : assert property (@(posedge clk) disable iff (rst)
            $fell(rxrq) |-> $past(rx_empty));
      end else begin : g_rxrq_comb
         assign rxrq = ~rx_empty & ~rst;
      end
   endgenerate

   // R1: a push into a full FIFO raises the overflow flag
   a_r1_ovf_set : assert property (@(posedge clk) disable iff (rst)
      (rx_wr && rx_full) |=> ovf);
   a_r1_ovf_clr : assert property (@(posedge clk) disable iff (rst)
      (rx_wr && !rx_full) |=> !ovf);

endmodule

// File: rtl/i2c_tgt_tx_flags.sv
module i2c_tgt_tx_flags
   import i2c_tgt_status_pkg::*;
#(
   parameter int EARLY_SUPPORT = 1
) (
   input  logic    clk,
   input  logic    rst,
   input  bus_ev_t ev,
   input  logic    tx_empty,
   input  logic    early_en,
   output logic    txrq,
   output logic    unf
);

   initial begin : p_param_chk
      assert (EARLY_SUPPORT == 0 || EARLY_SUPPORT == 1)
         else $error("EARLY_SUPPORT must be 0 or 1");
   end

   logic eff_early;
   logic rd_bit;
   logic req_edge;
   logic xfer_end;
   logic txrq_q;
   logic unf_q;

   generate
      if (EARLY_SUPPORT == 1) begin : g_mode_sel
         assign eff_early = early_en;
      end else begin : g_mode_fixed
         assign eff_early = 1'b0;
      end
   endgenerate

   assign rd_bit   = ev.rw_slot & ev.rw_read & ev.addr_hit;
   assign req_edge = eff_early ? ev.scl_rise : ev.scl_fall;
   assign xfer_end = ev.start | ev.stop;

   always_ff @(posedge clk) begin
      if (rst) begin
         txrq_q <= 1'b0;
         unf_q  <= 1'b0;
      end else begin
         if (xfer_end) begin
            txrq_q <= 1'b0;
         end else if (rd_bit && req_edge) begin
            txrq_q <= 1'b1;
         end

         if (xfer_end) begin
            unf_q <= 1'b0;
         end else if (rd_bit && ev.scl_rise && tx_empty) begin
            unf_q <= 1'b1;
         end
      end
   end

   assign txrq = txrq_q;
   assign unf  = unf_q;

   // R3: request rises only after a matched read slot edge
   a_r3_txrq_cause : assert property (@(posedge clk) disable iff (rst)
      $rose(txrq) |-> $past(ev.rw_slot && ev.rw_read && ev.addr_hit
                            && (ev.scl_rise || ev.scl_fall)));
   // R4: transfer boundaries clear both transfer flags
   a_r4_boundary_clr : assert property (@(posedge clk) disable iff (rst)
      (ev.start || ev.stop) |=> (!txrq && !unf));
   // R5: underflow needs a rising edge with an empty transmit FIFO
   a_r5_unf_cause : assert property (@(posedge clk) disable iff (rst)
      $rose(unf) |-> $past(ev.scl_rise && tx_empty));

endmodule

// File: rtl/i2c_tgt_etx_flag.sv
module i2c_tgt_etx_flag #(
   parameter int EARLY_SUPPORT = 1
) (
   input  logic clk,
   input  logic rst,
   input  logic scl_rise,
   input  logic rw_slot,
   input  logic addr_hit,
   input  logic xfer_end,
   input  logic tx_empty,
   input  logic early_en,
   input  logic stat_rd,
   output logic etx
);

   logic eff_early;
   logic fired_q;
   logic etx_q;
   logic fire;

   generate
      if (EARLY_SUPPORT == 1) begin : g_mode_sel
         assign eff_early = early_en;
      end else begin : g_mode_fixed
         assign eff_early = 1'b0;
      end
   endgenerate

   assign fire = eff_early & scl_rise & rw_slot & addr_hit & ~fired_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         fired_q <= 1'b0;
         etx_q   <= 1'b0;
      end else begin
         if (xfer_end) begin
            fired_q <= 1'b0;
         end else if (fire) begin
            fired_q <= 1'b1;
         end

         if (!eff_early) begin
            etx_q <= tx_empty;
         end else if (fire) begin
            etx_q <= 1'b1;
         end else if (stat_rd) begin
            etx_q <= 1'b0;
         end
      end
   end

   assign etx = etx_q;

   // R6: in normal mode the flag mirrors the transmit FIFO level
   a_r6_follow : assert property (@(posedge clk) disable iff (rst)
      !eff_early |=> (etx == $past(tx_empty)));
   // R7: once fired in a transfer, no further rise until START/STOP
   a_r7_once : assert property (@(posedge clk) disable iff (rst)
      (eff_early && fired_q && !xfer_end) |=> !$rose(etx));
   // R8: a read without a coincident setting edge clears the flag
   a_r8_read_clr : assert property (@(posedge clk) disable iff (rst)
      (eff_early && stat_rd && !(scl_rise && rw_slot)) |=> !etx);

endmodule

// File: rtl/i2c_tgt_status.sv
module i2c_tgt_status
   import i2c_tgt_status_pkg::*;
#(
   parameter int EARLY_SUPPORT    = 1,
   parameter int RXREQ_REGISTERED = 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              rw_slot,
   input  logic              rw_read,
   input  logic              addr_hit,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              rx_wr,
   input  logic              rx_full,
   input  logic              rx_empty,
   input  logic              tx_empty,
   input  logic              stat_rd,
   input  logic              early_en,
   input  logic              rx_irq_en,
   input  logic              tx_irq_en,
   output logic [STAT_W-1:0] status,
   output logic              irq
);

   bus_ev_t ev;
   stat_t   st;

   assign ev = '{scl_rise: scl_rise, scl_fall: scl_fall, rw_slot: rw_slot,
                 rw_read: rw_read, addr_hit: addr_hit, start: start_det,
                 stop: stop_det};

   i2c_tgt_rx_flags #(
      .RXREQ_REGISTERED (RXREQ_REGISTERED)
   ) rx_i (
      .clk      (clk),
      .rst      (rst),
      .rx_wr    (rx_wr),
      .rx_full  (rx_full),
      .rx_empty (rx_empty),
      .ovf      (st.ovf),
      .rxrq     (st.rxrq)
   );

   i2c_tgt_tx_flags #(
      .EARLY_SUPPORT (EARLY_SUPPORT)
   ) tx_i (
      .clk      (clk),
      .rst      (rst),
      .ev       (ev),
      .tx_empty (tx_empty),
      .early_en (early_en),
      .txrq     (st.txrq),
      .unf      (st.unf)
   );

   i2c_tgt_etx_flag #(
      .EARLY_SUPPORT (EARLY_SUPPORT)
   ) etx_i (
      .clk      (clk),
      .rst      (rst),
      .scl_rise (scl_rise),
      .rw_slot  (rw_slot),
      .addr_hit (addr_hit),
      .xfer_end (start_det | stop_det),
      .tx_empty (tx_empty),
      .early_en (early_en),
      .stat_rd  (stat_rd),
      .etx      (st.etx)
   );

   assign status = st;
   assign irq    = (st.rxrq & rx_irq_en) | (st.txrq & tx_irq_en);

   // R9: with both enables off the interrupt stays low
   a_r9_irq_masked : assert property (@(posedge clk) disable iff (rst)
      (!rx_irq_en && !tx_irq_en) |-> !irq);
   // R10: the first cycle after reset shows a clean status word
   a_r10_reset_clean : assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (status == '0 && !irq));

endmodule

// File: tb/i2c_tgt_status_tb_top.sv
module i2c_tgt_status_tb_top;

   logic       clk = 1'b0;
   logic       rst;
   logic       scl_rise, scl_fall, rw_slot, rw_read, addr_hit;
   logic       start_det, stop_det, rx_wr, rx_full, rx_empty, tx_empty;
   logic       stat_rd, early_en, rx_irq_en, tx_irq_en;
   logic [4:0] status;
   logic       irq;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   i2c_tgt_status dut_i (
      .clk (clk), .rst (rst), .scl_rise (scl_rise), .scl_fall (scl_fall),
      .rw_slot (rw_slot), .rw_read (rw_read), .addr_hit (addr_hit),
      .start_det (start_det), .stop_det (stop_det), .rx_wr (rx_wr),
      .rx_full (rx_full), .rx_empty (rx_empty), .tx_empty (tx_empty),
      .stat_rd (stat_rd), .early_en (early_en), .rx_irq_en (rx_irq_en),
      .tx_irq_en (tx_irq_en), .status (status), .irq (irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // wait one edge (inputs were set at a falling edge), then drop strobes
   task automatic tick();
      @(negedge clk);
      scl_rise = 0; scl_fall = 0; start_det = 0; stop_det = 0;
      rx_wr = 0; stat_rd = 0;
   endtask

   task automatic t_reset();
      rst = 1; scl_rise = 0; scl_fall = 0; rw_slot = 0; rw_read = 0;
      addr_hit = 0; start_det = 0; stop_det = 0; rx_wr = 0; rx_full = 0;
      rx_empty = 0; tx_empty = 1; stat_rd = 0; early_en = 0;
      rx_irq_en = 1; tx_irq_en = 1;
      repeat (3) @(negedge clk);
      chk("R10 status in reset", {3'b0, status}, 8'h00);
      chk("R10 irq in reset", {7'b0, irq}, 8'h00);
      rx_empty = 1; tx_empty = 0; rx_irq_en = 0; tx_irq_en = 0;
      rst = 0;
      tick();
      chk("R10 status after reset", {3'b0, status}, 8'h00);
   endtask

   task automatic t_rx();
      rx_empty = 0; tick();
      chk("R2 rx request set", {7'b0, status[3]}, 8'h01);
      rx_full = 1; rx_wr = 1; tick();
      chk("R1 R10 overflow packing", {3'b0, status}, 8'h18);
      tick();
      chk("R1 overflow holds", {7'b0, status[4]}, 8'h01);
      rx_full = 0; rx_wr = 1; tick();
      chk("R1 overflow clears on clean push", {7'b0, status[4]}, 8'h00);
      rx_full = 1; rx_wr = 1; tick();
      chk("R1 overflow again", {7'b0, status[4]}, 8'h01);
      rx_full = 0; rx_empty = 1; tick();
      chk("R1 R2 flush clears", {6'b0, status[4:3]}, 8'h00);
   endtask

   task automatic t_tx_normal();
      early_en = 0;
      start_det = 1; tick();
      rw_slot = 1; rw_read = 1; addr_hit = 1;
      scl_rise = 1; tick();
      chk("R3 no request on rise in normal mode", {7'b0, status[2]}, 8'h00);
      scl_fall = 1; tick();
      chk("R3 request on fall in normal mode", {3'b0, status}, 8'h04);
      chk("R9 irq masked", {7'b0, irq}, 8'h00);
      tx_irq_en = 1; #1;
      chk("R9 irq from tx request", {7'b0, irq}, 8'h01);
      @(negedge clk);
      stop_det = 1; tick();
      chk("R4 stop clears request", {7'b0, status[2]}, 8'h00);
      chk("R9 irq drops", {7'b0, irq}, 8'h00);
      start_det = 1; tick();
      addr_hit = 0; scl_fall = 1; tick();
      chk("R3 no request without address match", {7'b0, status[2]}, 8'h00);
      addr_hit = 1; rw_read = 0; scl_fall = 1; tick();
      chk("R3 no request on write bit", {7'b0, status[2]}, 8'h00);
      rw_slot = 0; tx_irq_en = 0;
   endtask

   task automatic t_tx_early();
      early_en = 1;
      start_det = 1; tick();
      stat_rd = 1; tick();
      rw_slot = 1; rw_read = 1; addr_hit = 1;
      scl_fall = 1; tick();
      chk("R3 no request on fall in early mode", {7'b0, status[2]}, 8'h00);
      scl_rise = 1; tick();
      chk("R3 R7 request and early flag on rise", {3'b0, status}, 8'h05);
      start_det = 1; tick();
      chk("R4 start clears request", {7'b0, status[2]}, 8'h00);
      rw_slot = 0; stat_rd = 1; tick();
      early_en = 0;
   endtask

   task automatic t_underflow();
      early_en = 0; tx_empty = 1; tick();
      chk("R6 early flag follows empty", {7'b0, status[0]}, 8'h01);
      start_det = 1; tick();
      rw_slot = 1; rw_read = 1; addr_hit = 1; scl_rise = 1; tick();
      chk("R5 underflow on empty read", {7'b0, status[1]}, 8'h01);
      stop_det = 1; tick();
      chk("R4 stop clears underflow", {7'b0, status[1]}, 8'h00);
      tx_empty = 0; start_det = 1; tick();
      chk("R6 early flag follows non-empty", {7'b0, status[0]}, 8'h00);
      scl_rise = 1; tick();
      chk("R5 no underflow with data", {7'b0, status[1]}, 8'h00);
      stop_det = 1; tick();
      rw_slot = 0;
   endtask

   task automatic t_early_once();
      early_en = 1; tx_empty = 1;
      start_det = 1; tick();
      stat_rd = 1; tick();
      chk("R8 read clears early flag", {7'b0, status[0]}, 8'h00);
      rw_slot = 1; rw_read = 0; addr_hit = 1; scl_rise = 1; tick();
      chk("R7 early flag on write bit rise", {7'b0, status[0]}, 8'h01);
      tick();
      chk("R8 early flag holds without read", {7'b0, status[0]}, 8'h01);
      stat_rd = 1; tick();
      chk("R8 read clears after fire", {7'b0, status[0]}, 8'h00);
      scl_rise = 1; tick();
      chk("R7 second rise in transfer ignored", {7'b0, status[0]}, 8'h00);
      stop_det = 1; tick();
      start_det = 1; tick();
      scl_rise = 1; stat_rd = 1; tick();
      chk("R7 R8 re-armed and set beats read", {7'b0, status[0]}, 8'h01);
      rw_slot = 0; stop_det = 1; stat_rd = 1; tick();
      early_en = 0; tx_empty = 0; tick();
   endtask

   task automatic t_rx_irq();
      rx_empty = 0; tick();
      chk("R9 irq masked with data", {7'b0, irq}, 8'h00);
      rx_irq_en = 1; #1;
      chk("R9 irq from rx request", {7'b0, irq}, 8'h01);
      @(negedge clk);
      rx_empty = 1; tick();
      chk("R2 R9 drain drops irq", {7'b0, irq}, 8'h00);
      rx_irq_en = 0;
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_rx();
            t_tx_normal();
            t_tx_early();
            t_underflow();
            t_early_once();
            t_rx_irq();
         end
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule